// File: doc/BRIEF.md
# Frame Segmenter With CRC Trailer

This block turns one outgoing data frame, delivered as a byte stream from a transmit ring, into a train of tunneled packets. It runs a CRC32 over the frame's data bytes and appends the four result bytes after the last data byte. The combined stream (data followed by CRC) is then cut into packets of a fixed maximum payload size. Each packet leaves the block as a burst of bytes on consecutive cycles. Every byte of the burst carries the packet's header fields:
- a position code that marks the packet as the start, middle or end of the frame;
- a hop identifier equal to the ring index;
- the payload length;
- a header check field, left at zero for a later stage to fill in.

Each packet is staged in a small packet RAM before it is sent, because the length must be known when the packet's first byte goes out. The input side therefore pauses while a packet drains. A frame may reach the block in several pieces separated by idle cycles. Those pieces have no effect on where packets are cut. If a frame runs longer than the maximum frame size, the excess bytes are consumed and thrown away, and the frame's final packet is flagged as truncated.

Top module: `frame_segmenter`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high.
- R2: The bytes leaving the block are the frame's kept data bytes in arrival order, followed by their CRC32. The CRC is the reflected form of polynomial 0x04C11DB7 (shift constant 0xEDB88320), starts from all ones and is inverted at the end. It is sent least significant byte first, so the string "123456789" yields bytes 26 39 F4 CB.
- R3: Every packet except the frame's last one carries exactly MAX_PAY bytes, and the last packet carries the remainder (1 to MAX_PAY bytes). `out_len` equals the packet's byte count, CRC bytes included, and it holds steady for the whole packet.
- R4: The first packet of a multi-packet frame carries the start code in `out_pos`. Middle packets carry 0. The last packet carries the end code. A frame that fits in one packet carries only the end code.
- R5: `out_hop`, and the start and end codes used for a frame, are the values of `ring_idx`, `start_code` and `end_code` sampled when that frame's first byte is accepted. Later changes to those inputs during the frame have no effect.
- R6: `out_hec` is zero on every emitted byte.
- R7: When a frame exceeds MAX_FRAME data bytes, only the first MAX_FRAME bytes are kept and the CRC covers only those bytes. The remaining input bytes, up to and including the one with `in_last`, are accepted and discarded. `out_trunc` is high on the bytes of that frame's final packet and low on all other bytes.
- R8: A packet is released only when MAX_PAY bytes are staged or the frame's CRC has been fully staged. A pause in `in_valid` partway through a frame emits nothing, and it does not move any packet boundary.
- R9: A packet's bytes appear on consecutive cycles. `out_sop` is high on the first byte and `out_eop` on the last.
- R10: A frame of exactly MAX_FRAME bytes, with `in_last` on its final byte, is not truncated.
- R11: When the data ends fewer than four bytes before a packet boundary, the CRC bytes are split across two packets, with the trailing CRC bytes forming the start of the final packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Frame data byte |
| in_last | input | 1 | Marks the frame's final input byte |
| ring_idx | input | RING_W | Transmit ring index, becomes the hop identifier |
| start_code | input | POS_W | Position code for a frame's first packet |
| end_code | input | POS_W | Position code for a frame's last packet |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Payload byte |
| out_sop | output | 1 | First byte of a packet |
| out_eop | output | 1 | Last byte of a packet |
| out_pos | output | POS_W | Position code of the packet |
| out_hop | output | RING_W | Hop identifier of the packet |
| out_len | output | LEN_W | Payload byte count of the packet |
| out_hec | output | HEC_W | Header check field, always zero |
| out_trunc | output | 1 | Final packet of a truncated frame |

## Verification
The bench builds the block with MAX_PAY=8 and MAX_FRAME=24. With these values a few dozen input bytes are enough to reach every corner:
- a single-packet frame;
- an exact fill of one packet, which leaves a CRC-only final packet;
- a CRC split across two packets;
- a frame of exactly the maximum size;
- truncation followed by a clean next frame.

A behavioural model predicts every output byte and its header fields from the input frame. The model's predictions are compared against the outputs on every cycle. Mid-frame input pauses and changes to the ring index and position codes after the first byte are included in the stimulus.

// File: rtl/fseg_pkg.sv
package fseg_pkg;

  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_TAIL = 2'd1,
    ST_SEND = 2'd2,
    ST_DROP = 2'd3
  } fseg_state_e;

  localparam logic [31:0] CRC_SHIFT_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED       = 32'hFFFFFFFF;
  localparam int          CRC_BYTES      = 4;

  // One byte of the reflected CRC32, processed bit by bit, LSB first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_SHIFT_POLY;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/fseg_crc.sv
module fseg_crc
  import fseg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= CRC_SEED;
    else if (en)     crc_q <= crc32_step(crc_q, din);
  end

endmodule

// File: rtl/fseg_pktbuf.sv
module fseg_pktbuf #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/fseg_emit.sv
module fseg_emit #(
  parameter int POS_W  = 4,
  parameter int RING_W = 6,
  parameter int LEN_W  = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              sop,
  input  logic              eop,
  input  logic [POS_W-1:0]  pos,
  input  logic [RING_W-1:0] hop,
  input  logic [LEN_W-1:0]  len,
  input  logic              trunc,
  output logic              out_valid,
  output logic              out_sop,
  output logic              out_eop,
  output logic [POS_W-1:0]  out_pos,
  output logic [RING_W-1:0] out_hop,
  output logic [LEN_W-1:0]  out_len,
  output logic              out_trunc
);

  // Aligned with the one-cycle read latency of the packet RAM.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      out_pos   <= '0;
      out_hop   <= '0;
      out_len   <= '0;
      out_trunc <= 1'b0;
    end else begin
      out_valid <= issue;
      out_sop   <= issue && sop;
      out_eop   <= issue && eop;
      out_trunc <= issue && trunc;
      if (issue) begin
        out_pos <= pos;
        out_hop <= hop;
        out_len <= len;
      end
    end
  end

endmodule

// File: rtl/frame_segmenter.sv
module frame_segmenter
  import fseg_pkg::*;
#(
  parameter int MAX_PAY   = 256,
  parameter int MAX_FRAME = 4096,
  parameter int POS_W     = 4,
  parameter int RING_W    = 6,
  parameter int HEC_W     = 8,
  localparam int LEN_W    = $clog2(MAX_PAY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [RING_W-1:0] ring_idx,
  input  logic [POS_W-1:0]  start_code,
  input  logic [POS_W-1:0]  end_code,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [POS_W-1:0]  out_pos,
  output logic [RING_W-1:0] out_hop,
  output logic [LEN_W-1:0]  out_len,
  output logic [HEC_W-1:0]  out_hec,
  output logic              out_trunc
);

  localparam int AW    = (MAX_PAY > 1) ? $clog2(MAX_PAY) : 1;
  localparam int FRM_W = $clog2(MAX_FRAME + 1);
  localparam logic [LEN_W-1:0] PAY_FULL  = LEN_W'(MAX_PAY);
  localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);
  localparam logic [FRM_W-1:0] FRM_FULL  = FRM_W'(MAX_FRAME);
  localparam logic [FRM_W-1:0] FRM_ONE   = FRM_W'(1);
  localparam logic [2:0]       CRC_DONE  = 3'(CRC_BYTES);

  fseg_state_e       state_q;
  logic [LEN_W-1:0]  wcnt_q, rcnt_q, plen_q;
  logic [FRM_W-1:0]  fcnt_q;
  logic [2:0]        cidx_q;
  logic              first_q, tail_q, drop_q, trunc_q, plast_q;
  logic [RING_W-1:0] hop_q;
  logic [POS_W-1:0]  sc_q, ec_q, ppos_q;

  logic              acc, data_end, send_done, crc_clr, buf_we;
  logic [LEN_W-1:0]  wnext;
  logic [FRM_W-1:0]  fnext;
  logic [2:0]        cnext;
  logic [31:0]       crc_q, crc_out;
  logic [7:0]        tail_byte, buf_wd;
  logic [POS_W-1:0]  cur_sc;

  always_comb begin
    acc       = (state_q == ST_FILL) && in_valid;
    wnext     = wcnt_q + LEN_ONE;
    fnext     = fcnt_q + FRM_ONE;
    cnext     = cidx_q + 3'd1;
    data_end  = in_last || (fnext == FRM_FULL);
    crc_out   = ~crc_q;
    tail_byte = crc_out[{cidx_q[1:0], 3'b000} +: 8];
    buf_we    = acc || (state_q == ST_TAIL);
    buf_wd    = (state_q == ST_TAIL) ? tail_byte : in_data;
    cur_sc    = (fcnt_q == '0) ? start_code : sc_q;
    send_done = (state_q == ST_SEND) && ((rcnt_q + LEN_ONE) == plen_q);
    crc_clr   = send_done && plast_q;
  end

  assign in_ready = (state_q == ST_FILL) || (state_q == ST_DROP);
  assign out_hec  = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FILL;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
      plen_q  <= '0;
      fcnt_q  <= '0;
      cidx_q  <= '0;
      first_q <= 1'b1;
      tail_q  <= 1'b0;
      drop_q  <= 1'b0;
      trunc_q <= 1'b0;
      plast_q <= 1'b0;
      hop_q   <= '0;
      sc_q    <= '0;
      ec_q    <= '0;
      ppos_q  <= '0;
    end else begin
      case (state_q)
        ST_FILL: begin
          if (in_valid) begin
            wcnt_q <= wnext;
            fcnt_q <= fnext;
            if (fcnt_q == '0) begin
              hop_q <= ring_idx;
              sc_q  <= start_code;
              ec_q  <= end_code;
            end
            if (data_end) begin
              tail_q  <= 1'b1;
              drop_q  <= !in_last;
              trunc_q <= !in_last;
            end
            if (wnext == PAY_FULL) begin
              // Full packet of data: CRC still follows, so never the last one.
              state_q <= ST_SEND;
              plen_q  <= wnext;
              plast_q <= 1'b0;
              ppos_q  <= first_q ? cur_sc : '0;
              first_q <= 1'b0;
              rcnt_q  <= '0;
            end else if (data_end) begin
              state_q <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          wcnt_q <= wnext;
          cidx_q <= cnext;
          if (cnext == CRC_DONE) begin
            state_q <= ST_SEND;
            plen_q  <= wnext;
            plast_q <= 1'b1;
            ppos_q  <= ec_q;
            first_q <= 1'b0;
            rcnt_q  <= '0;
          end else if (wnext == PAY_FULL) begin
            state_q <= ST_SEND;
            plen_q  <= wnext;
            plast_q <= 1'b0;
            ppos_q  <= first_q ? sc_q : '0;
            first_q <= 1'b0;
            rcnt_q  <= '0;
          end
        end
        ST_SEND: begin
          rcnt_q <= rcnt_q + LEN_ONE;
          if (send_done) begin
            wcnt_q <= '0;
            if (plast_q) begin
              fcnt_q  <= '0;
              first_q <= 1'b1;
              tail_q  <= 1'b0;
              cidx_q  <= '0;
              trunc_q <= 1'b0;
              drop_q  <= 1'b0;
              state_q <= drop_q ? ST_DROP : ST_FILL;
            end else begin
              state_q <= tail_q ? ST_TAIL : ST_FILL;
            end
          end
        end
        ST_DROP: begin
          if (in_valid && in_last) state_q <= ST_FILL;
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  fseg_crc u_crc (
    .clk   (clk),
    .rst   (rst),
    .clr   (crc_clr),
    .en    (acc),
    .din   (in_data),
    .crc_q (crc_q)
  );

  fseg_pktbuf #(
    .DEPTH (MAX_PAY),
    .AW    (AW)
  ) u_buf (
    .clk     (clk),
    .wr_en   (buf_we),
    .wr_addr (wcnt_q[AW-1:0]),
    .wr_data (buf_wd),
    .rd_en   (state_q == ST_SEND),
    .rd_addr (rcnt_q[AW-1:0]),
    .rd_data (out_data)
  );

  fseg_emit #(
    .POS_W  (POS_W),
    .RING_W (RING_W),
    .LEN_W  (LEN_W)
  ) u_emit (
    .clk       (clk),
    .rst       (rst),
    .issue     (state_q == ST_SEND),
    .sop       (rcnt_q == '0),
    .eop       ((rcnt_q + LEN_ONE) == plen_q),
    .pos       (ppos_q),
    .hop       (hop_q),
    .len       (plen_q),
    .trunc     (plast_q && trunc_q),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_pos   (out_pos),
    .out_hop   (out_hop),
    .out_len   (out_len),
    .out_trunc (out_trunc)
  );

endmodule

// File: rtl/fseg_chk.sv
module fseg_chk #(
  parameter int MAX_PAY = 256,
  parameter int POS_W   = 4,
  parameter int RING_W  = 6,
  parameter int LEN_W   = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_sop,
  input logic              out_eop,
  input logic [POS_W-1:0]  out_pos,
  input logic [RING_W-1:0] out_hop,
  input logic [LEN_W-1:0]  out_len,
  input logic              out_trunc
);

  logic [LEN_W-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)            bcnt <= '0;
    else if (out_valid) bcnt <= out_eop ? '0 : bcnt + LEN_W'(1);
  end

  // R1: nothing leaves in the first cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R3: length inside the legal range
  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len != '0 && out_len <= LEN_W'(MAX_PAY)));

  // R3: header fields steady through a packet
  p_hdr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> ($stable(out_len) && $stable(out_pos) &&
                                 $stable(out_hop) && $stable(out_trunc)));

  // R3: counted bytes match the length field
  p_count_len_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eop) |-> ((bcnt + LEN_W'(1)) == out_len));

  // R9: packet bytes are back to back
  p_contig_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eop) |=> (out_valid && !out_sop));

  // R9: a burst opens with a start marker
  p_burst_sop_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(out_valid)) |-> out_sop);

endmodule

bind frame_segmenter fseg_chk #(
  .MAX_PAY (MAX_PAY),
  .POS_W   (POS_W),
  .RING_W  (RING_W),
  .LEN_W   (LEN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_pos   (out_pos),
  .out_hop   (out_hop),
  .out_len   (out_len),
  .out_trunc (out_trunc)
);

// File: tb/frame_segmenter_tb.sv
module frame_segmenter_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PAY   = 8;
  localparam int FRM   = 24;
  localparam int POSW  = 4;
  localparam int RINGW = 6;
  localparam int LENW  = $clog2(PAY + 1);

  typedef struct packed {
    logic [7:0]       d;
    logic             sop;
    logic             eop;
    logic [POSW-1:0]  pos;
    logic [RINGW-1:0] hop;
    logic [LENW-1:0]  len;
    logic             trunc;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic [RINGW-1:0] ring_idx = '0;
  logic [POSW-1:0] start_code = '0, end_code = '0;
  logic in_ready, out_valid, out_sop, out_eop, out_trunc;
  logic [7:0] out_data;
  logic [POSW-1:0] out_pos;
  logic [RINGW-1:0] out_hop;
  logic [LENW-1:0] out_len;
  logic [7:0] out_hec;

  int n_chk = 0, n_bad = 0;
  int gap_seen = 0;
  bit watch = 1'b0;
  int seed = 1;
  exp_t exp_q[$];
  logic [7:0] frm[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_segmenter #(
    .MAX_PAY (PAY), .MAX_FRAME (FRM), .POS_W (POSW), .RING_W (RINGW), .HEC_W (8)
  ) u_dut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .in_last (in_last), .ring_idx (ring_idx),
    .start_code (start_code), .end_code (end_code), .out_valid (out_valid),
    .out_data (out_data), .out_sop (out_sop), .out_eop (out_eop),
    .out_pos (out_pos), .out_hop (out_hop), .out_len (out_len),
    .out_hec (out_hec), .out_trunc (out_trunc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int k);
    logic [31:0] r = 32'hFFFFFFFF;
    for (int i = 0; i < k; i++) begin
      r = r ^ {24'h0, frm[i]};
      for (int b = 0; b < 8; b++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    end
    return ~r;
  endfunction

  // Output monitor: every output byte is checked against the model queue.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (watch) gap_seen++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8", "unexpected output byte", {24'h0, out_data}, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(out_data == e.d, "R2", "data byte", {24'h0, out_data}, {24'h0, e.d});
        chk(out_len == e.len, "R3", "length field", 32'(out_len), 32'(e.len));
        chk(out_pos == e.pos, "R4", "position code", 32'(out_pos), 32'(e.pos));
        chk(out_hop == e.hop, "R5", "hop id", 32'(out_hop), 32'(e.hop));
        chk(out_hec == 8'h0, "R6", "header check", 32'(out_hec), 32'h0);
        chk(out_trunc == e.trunc, "R7", "trunc flag", 32'(out_trunc), 32'(e.trunc));
        chk(out_sop == e.sop && out_eop == e.eop, "R9", "sop/eop",
            {30'h0, out_sop, out_eop}, {30'h0, e.sop, e.eop});
      end
    end
  end

  task automatic fill_pattern(input int n);
    frm.delete();
    for (int i = 0; i < n; i++) frm.push_back(8'(seed * 29 + i * 13 + 7));
    seed++;
  endtask

  task automatic fill_ascii();
    frm.delete();
    for (int i = 0; i < 9; i++) frm.push_back(8'(8'h31 + i));
  endtask

  // Builds expected packets for frm, then drives it. Must be called at a negedge.
  task automatic send_frame(input int gap_every, input int stall_at,
                            input logic [RINGW-1:0] ring,
                            input logic [POSW-1:0] sc, input logic [POSW-1:0] ec);
    int n, k, total, npk, len;
    bit tr;
    logic [31:0] c;
    logic [7:0] s[$];
    n = frm.size();
    k = (n > FRM) ? FRM : n;
    tr = (n > FRM);
    c = ref_crc(k);
    for (int i = 0; i < k; i++) s.push_back(frm[i]);
    for (int j = 0; j < 4; j++) s.push_back(c[8*j +: 8]);
    total = s.size();
    npk = (total + PAY - 1) / PAY;
    for (int p = 0; p < npk; p++) begin
      exp_t e;
      len = (p == npk - 1) ? total - p * PAY : PAY;
      for (int b = 0; b < len; b++) begin
        e.d = s[p * PAY + b];
        e.sop = (b == 0);
        e.eop = (b == len - 1);
        e.pos = (p == npk - 1) ? ec : ((p == 0) ? sc : '0);
        e.hop = ring;
        e.len = LENW'(len);
        e.trunc = tr && (p == npk - 1);
        exp_q.push_back(e);
      end
    end
    ring_idx = ring; start_code = sc; end_code = ec;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = frm[i]; in_last = (i == n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      if (i == 0) begin
        ring_idx = ~ring; start_code = ~sc; end_code = ~ec;
      end
      if (stall_at == i + 1) begin
        in_valid = 1'b0;
        gap_seen = 0; watch = 1'b1;
        repeat (20) @(negedge clk);
        watch = 1'b0;
        chk(gap_seen == 0, "R8", "output during mid-frame pause", 32'(gap_seen), 32'h0);
      end else if (gap_every > 0) begin
        in_valid = 1'b0;
        repeat (gap_every) @(negedge clk);
      end
    end
    in_valid = 1'b0; in_last = 1'b0;
    for (int t = 0; t < 300 && exp_q.size() != 0; t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "bytes missing at frame end", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'h0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'h1);

    fill_ascii();
    chk(ref_crc(9) == 32'hCBF43926, "R2", "model CRC check value", ref_crc(9), 32'hCBF43926);
    send_frame(0, 0, 6'h11, 4'hA, 4'h3);   // R2 R4: 13 bytes, two packets
    fill_pattern(1);  send_frame(0, 0, 6'h05, 4'h9, 4'h6);  // R4 single-packet frame
    fill_pattern(4);  send_frame(0, 0, 6'h2A, 4'hC, 4'h5);  // R3 exact single fill
    fill_pattern(5);  send_frame(0, 0, 6'h3F, 4'h1, 4'h2);  // R11 CRC split 3+1
    fill_pattern(8);  send_frame(0, 0, 6'h07, 4'hB, 4'hE);  // R11 CRC-only final packet
    fill_pattern(17); send_frame(0, 0, 6'h19, 4'h4, 4'h8);  // R4 middle packets carry 0
    fill_pattern(24); send_frame(0, 0, 6'h22, 4'h7, 4'hD);  // R10 exact maximum
    fill_pattern(30); send_frame(0, 0, 6'h0C, 4'h6, 4'h9);  // R7 truncation
    fill_pattern(3);  send_frame(0, 0, 6'h31, 4'h2, 4'hF);  // R7 next frame clean
    fill_pattern(11); send_frame(2, 0, 6'h15, 4'hD, 4'h1);  // R8 gaps keep boundaries
    fill_pattern(13); send_frame(0, 3, 6'h2E, 4'h5, 4'hA);  // R8 mid-frame pause
    fill_pattern(27); send_frame(1, 0, 6'h01, 4'h8, 4'h4);  // R7 R5 truncation with gaps

    repeat (10) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule